// File: doc/BRIEF.md
# Hot-plug detect deglitch filter

This block turns a raw, asynchronous hot-plug detect pin into a clean connection level. It also produces single-cycle rise and fall event pulses for a downstream interrupt block. The pin first crosses into the clock domain through a chain of synchroniser flops. It then passes two chained filter stages. The first is a short glitch rejector whose width N comes from a 4-bit configuration field. The second is a coarse stability qualifier whose width comes from a 12-bit field M, counted in units of 1024 clock cycles.

Both filter stages use the same rule. A stage adopts a new input level only after that level has differed from the stage's held value for more than the threshold number of consecutive cycles. If the input goes back to the held value first, the stage's counter restarts. With a field at zero, its stage rejects nothing and only adds one register of delay.

The qualified level is available as a status output. Rise and fall events are derived from this level, never from the raw pin.

Top module: `hpd_filter_top`

## Requirements
- R1: When the pin changes and then stays at its new value, the status output takes that value on exactly the (4 + N + M*1024)-th rising clock edge. The first edge that samples the changed pin counts as edge 1.
- R2: With M = 0, a pin pulse of N or fewer cycles causes no change of status and no event. A pulse of N+1 cycles produces exactly one rise event and one fall event.
- R3: With a valid-width field M, a level that holds for M*1024 cycles or fewer is rejected. A level that holds for M*1024+1 cycles is accepted. M counts in units of 1024 clock cycles.
- R4: With N = 0 and M = 0, a pulse of a single cycle is passed through and produces one rise event and one fall event.
- R5: While reset (synchronous, active high) is applied, and in the cycle after it is released, the status output is 0 and both event outputs are 0. This holds even if the pin is held high.
- R6: A 0-to-1 change of status produces a rise pulse that is high for exactly one cycle. The pulse is high in the cycle after the status rises.
- R7: A 1-to-0 change of status produces a fall pulse that is high for exactly one cycle. The pulse is high in the cycle after the status falls.
- R8: If the glitch-filtered level goes back before the stability threshold is reached, the stability count restarts from zero. Two 1000-cycle high periods separated by a short low period are therefore rejected when M = 1.
- R9: The rise and fall outputs are never high in the same cycle. Neither output is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hpd_raw_i | input | 1 | Raw asynchronous hot-plug detect pin |
| cfg_glitch_i | input | 4 | Glitch width N: pulses of N cycles or fewer are discarded |
| cfg_valid_i | input | 12 | Valid width M: levels stable for M*1024 cycles or fewer are discarded |
| hpd_level_o | output | 1 | Filtered connection level (status) |
| hpd_rise_o | output | 1 | One-cycle pulse on a rising edge of the filtered level |
| hpd_fall_o | output | 1 | One-cycle pulse on a falling edge of the filtered level |

## Verification
A table of single pin pulses is walked, each pulse sitting one cycle on either side of a threshold: N cycles against N+1, and M*1024 against M*1024+1. This shows whether each stage draws its boundary in the right place and whether the two thresholds combine correctly. Sustained rising and falling steps are timed to the exact edge, which separates a wrong synchroniser depth or an off-by-one count from a correct filter. An interrupted high period, short enough to pass the glitch stage, shows whether the stability count truly restarts or only pauses. A pin held high through reset shows that no event leaks out of reset.

// File: rtl/hpd_filt_pkg.sv
package hpd_filt_pkg;
  localparam int DEF_GLITCH_W   = 4;
  localparam int DEF_VALID_W    = 12;
  localparam int DEF_UNIT_LOG2  = 10;
  localparam int DEF_SYNC_DEPTH = 2;

  // Expand a coarse width field into a cycle threshold.
  function automatic logic [DEF_VALID_W+DEF_UNIT_LOG2-1:0] coarse_cycles(
    input logic [DEF_VALID_W-1:0] field
  );
    return {field, {DEF_UNIT_LOG2{1'b0}}};
  endfunction
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic din_i,
  output logic dout_o
);
  logic [DEPTH-1:0] chain_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[0] <= 1'b0;
          else       chain_q[0] <= din_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[i] <= 1'b0;
          else       chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout_o = chain_q[DEPTH-1];
endmodule

// File: rtl/hpd_hold_stage.sv
module hpd_hold_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             din_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             dout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  // A new level is adopted once it has differed for more than thr_i cycles.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (din_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= thr_i) begin
      lvl_q <= din_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout_o = lvl_q;

  // R2 / R3: the held level only moves toward a value the input carried.
  assert_hold_follows_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (lvl_q != $past(lvl_q)) |-> ($past(din_i) == lvl_q));

  // R3: a change needs the counter to have reached the threshold.
  assert_hold_threshold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) >= $past(thr_i)));

  // R8: an input matching the held level restarts the count.
  assert_count_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (din_i == lvl_q) |=> (cnt_q == '0));
endmodule

// File: rtl/hpd_edge_events.sv
module hpd_edge_events (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      rise_q <= level_i & ~prev_q;
      fall_q <= ~level_i & prev_q;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_rise_after_edge_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |-> ($past(level_i) && !$past(level_i, 2)));

  assert_fall_after_edge_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_o |-> (!$past(level_i) && $past(level_i, 2)));

  assert_events_exclusive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rise_o && fall_o));

  assert_rise_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

  assert_fall_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_o |=> !fall_o);

  assert_quiet_after_reset_R5: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!rise_o && !fall_o));
endmodule

// File: rtl/hpd_filter_top.sv
module hpd_filter_top
  import hpd_filt_pkg::*;
#(
  parameter int GLITCH_W   = DEF_GLITCH_W,
  parameter int VALID_W    = DEF_VALID_W,
  parameter int UNIT_LOG2  = DEF_UNIT_LOG2,
  parameter int SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                hpd_raw_i,
  input  logic [GLITCH_W-1:0] cfg_glitch_i,
  input  logic [VALID_W-1:0]  cfg_valid_i,
  output logic                hpd_level_o,
  output logic                hpd_rise_o,
  output logic                hpd_fall_o
);
  localparam int STAB_W = VALID_W + UNIT_LOG2;

  logic              pin_sync;
  logic              deglitched;
  logic              qualified;
  logic [STAB_W-1:0] stab_thr;

  assign stab_thr = {cfg_valid_i, {UNIT_LOG2{1'b0}}};

  hpd_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .din_i  (hpd_raw_i),
    .dout_o (pin_sync)
  );

  hpd_hold_stage #(.CNT_W(GLITCH_W)) u_glitch (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .din_i  (pin_sync),
    .thr_i  (cfg_glitch_i),
    .dout_o (deglitched)
  );

  hpd_hold_stage #(.CNT_W(STAB_W)) u_stable (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .din_i  (deglitched),
    .thr_i  (stab_thr),
    .dout_o (qualified)
  );

  hpd_edge_events u_events (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .level_i (qualified),
    .rise_o  (hpd_rise_o),
    .fall_o  (hpd_fall_o)
  );

  assign hpd_level_o = qualified;

  assert_level_reset_R5: assert property (@(posedge clk_i)
    $past(rst_i) |-> !hpd_level_o);

  assert_rise_matches_level_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hpd_level_o) |=> hpd_rise_o);
endmodule

// File: tb/test_hpd_filter_top.sv
`timescale 1ns/1ps
module test_hpd_filter_top;
  localparam int UNIT = 1024;

  typedef struct packed {
    logic [3:0]  n;
    logic [11:0] m;
    logic [15:0] w;
    logic        acc;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'd0,  12'd0, 16'd1,    1'b1},  // R4 / R2
    '{4'd3,  12'd0, 16'd3,    1'b0},  // R2 at N
    '{4'd3,  12'd0, 16'd4,    1'b1},  // R2 at N+1
    '{4'd15, 12'd0, 16'd15,   1'b0},  // R2 max field
    '{4'd15, 12'd0, 16'd16,   1'b1},
    '{4'd0,  12'd1, 16'd1024, 1'b0},  // R3 at M*1024
    '{4'd0,  12'd1, 16'd1025, 1'b1},  // R3 at M*1024+1
    '{4'd5,  12'd1, 16'd1000, 1'b0},
    '{4'd2,  12'd2, 16'd2048, 1'b0},
    '{4'd15, 12'd2, 16'd2049, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raw = 1'b0;
  logic [3:0]  cfg_n = '0;
  logic [11:0] cfg_m = '0;
  logic        level, rise, fall;

  int checks = 0;
  int fails  = 0;
  int rise_seen = 0;
  int fall_seen = 0;
  logic prev_rise = 1'b0;
  logic prev_fall = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hpd_filter_top i_hpd_filter_top (
    .clk_i        (clk),
    .rst_i        (rst),
    .hpd_raw_i    (raw),
    .cfg_glitch_i (cfg_n),
    .cfg_valid_i  (cfg_m),
    .hpd_level_o  (level),
    .hpd_rise_o   (rise),
    .hpd_fall_o   (fall)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Event monitor, sampled away from the active edge (R9).
  always @(negedge clk) begin
    if (!rst) begin
      if (rise) rise_seen++;
      if (fall) fall_seen++;
      if ((rise && fall) || (rise && prev_rise) || (fall && prev_fall)) begin
        checks++;
        fails++;
        $display("FAIL R9 event overlap: actual rise=%0d fall=%0d expected exclusive single pulses",
                 rise, fall);
      end
    end
    prev_rise = rise;
    prev_fall = fall;
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input logic target, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (level != target && n < limit);
  endtask

  task automatic step_test(input logic [3:0] n, input logic [11:0] m);
    int lat, exp;
    @(negedge clk);
    cfg_n = n; cfg_m = m; raw = 1'b0;
    wait_cycles(m * UNIT + 40);
    exp = 4 + n + m * UNIT;
    raw = 1'b1;
    measure(1'b1, exp + 50, lat);
    check("R1", lat, exp, "rise latency");
    @(negedge clk);
    check("R6", rise, 1, "rise pulse cycle after level");
    @(negedge clk);
    check("R6", rise, 0, "rise pulse one cycle");
    wait_cycles(20);
    raw = 1'b0;
    measure(1'b0, exp + 50, lat);
    check("R1", lat, exp, "fall latency");
    @(negedge clk);
    check("R7", fall, 1, "fall pulse cycle after level");
    @(negedge clk);
    check("R7", fall, 0, "fall pulse one cycle");
  endtask

  initial begin : watchdog
    #(190000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    // R5: pin held high through reset.
    raw = 1'b1;
    wait_cycles(10);
    check("R5", level, 0, "level in reset");
    check("R5", rise + fall, 0, "events in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R5", level, 0, "level after release");
    check("R5", rise_seen, 0, "no rise right after release");
    wait_cycles(20);
    raw = 1'b0;
    wait_cycles(20);

    // Table walk: single pulses around each threshold (R2, R3, R4).
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cfg_n = VECS[k].n; cfg_m = VECS[k].m; raw = 1'b0;
      wait_cycles(30);
      rise_seen = 0; fall_seen = 0;
      raw = 1'b1;
      wait_cycles(int'(VECS[k].w));
      raw = 1'b0;
      wait_cycles(int'(VECS[k].n) + int'(VECS[k].m) * UNIT + 30);
      check(VECS[k].m != 0 ? "R3" : (VECS[k].n == 0 ? "R4" : "R2"),
            rise_seen, int'(VECS[k].acc), $sformatf("rise count vec %0d", k));
      check(VECS[k].m != 0 ? "R3" : (VECS[k].n == 0 ? "R4" : "R2"),
            fall_seen, int'(VECS[k].acc), $sformatf("fall count vec %0d", k));
      check("R2", level, 0, $sformatf("level idle vec %0d", k));
    end

    // R1 / R6 / R7: exact step latency for several settings.
    step_test(4'd0, 12'd0);
    step_test(4'd7, 12'd0);
    step_test(4'd3, 12'd1);

    // R8: interrupted high period must restart the stability count.
    @(negedge clk);
    cfg_n = 4'd0; cfg_m = 12'd1; raw = 1'b0;
    wait_cycles(30);
    rise_seen = 0; fall_seen = 0;
    raw = 1'b1; wait_cycles(1000);
    raw = 1'b0; wait_cycles(5);
    raw = 1'b1; wait_cycles(1000);
    raw = 1'b0; wait_cycles(UNIT + 40);
    check("R8", rise_seen, 0, "interrupted high rejected");
    check("R8", level, 0, "level stays low");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule